// File: doc/BRIEF.md
# Loss-of-Lock Alarm with Zero-Run Detection

This block sits behind a clock and data recovery stage. It watches the parallel words it is given and a lock-status flag from the phase detector. From these it drives a single active-high loss-of-lock alarm. A long unbroken run of all-zero words is always treated as a fault. When the lock-mode input is high, a deasserted lock indication is also a fault.

Once the alarm has asserted, it does not drop as soon as the fault goes away. It stays up for a fixed hold-off, counted in word-clock cycles, and that count starts only after every active fault condition has gone. A fault that comes back during the hold-off restarts the count. Both the zero-run threshold and the hold-off are parameters. With the default 155.52 MHz word clock they are 514 words (about 3.3 us) and 15552 cycles (100 us). The lock flag is asynchronous to the word clock and is resynchronized inside the block.

Top module: `lol_alarm`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `lol_o` is 0.
- R2: After ZERO_RUN_WORDS consecutive sampled words equal to zero, `lol_o` goes to 1 on the next clock edge. After exactly ZERO_RUN_WORDS zero words it is still 0.
- R3: A word with any bit set restarts the zero run. Two runs of ZERO_RUN_WORDS-1 zeros split by one word with a single bit set (0x8000) never raise the alarm.
- R4: With `lock_mode_i` = 0, the value of `lock_ok_i` has no effect on `lol_o`.
- R5: With `lock_mode_i` = 1, a 0 on `lock_ok_i` passes through a two-flop synchronizer. `lol_o` goes high on the third clock edge after that 0 is first sampled.
- R6: Once no fault is present, `lol_o` stays 1 for HOLD_CYCLES clock edges that see no fault. It goes to 0 on the last of them.
- R7: With `lock_mode_i` = 1, the hold-off does not run while either the zero run or the loss of lock is still present. It starts only when both have cleared.
- R8: A fault seen during the hold-off keeps `lol_o` at 1 and restarts the hold-off count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | WORD_W | Recovered parallel data word, sampled every cycle |
| lock_ok_i | input | 1 | Phase lock good, asynchronous, 1 = locked |
| lock_mode_i | input | 1 | 1 = loss of lock also raises the alarm |
| lol_o | output | 1 | Loss-of-lock alarm, active high |

## Verification
Runs of zeros that stop one word short of the threshold and runs that reach it separate an off-by-one in the run counter from correct behaviour. A zero run broken by a single set bit shows that any set bit restarts the run, and not only whole non-zero words. The lock input is toggled with the mode off and with it on, which tells apart a gated lock term from one that always acts. It also measures the synchronizer latency. Overlapping faults, short lock glitches during the hold-off, and random bursts of zeros and lock changes separate a hold-off that restarts and waits for both faults to clear from one that starts on the first fault to clear.

// File: rtl/lol_alarm_pkg.sv
package lol_alarm_pkg;
  typedef enum logic {
    ALM_CLEAR = 1'b0,
    ALM_RAISED = 1'b1
  } alm_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/lol_sync.sv
module lol_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/lol_zero_run.sv
module lol_zero_run
  import lol_alarm_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned RUN_LEN = 514
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  output logic              run_hit_o
);
  localparam int unsigned CW = cnt_width(RUN_LEN);
  localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

  logic [CW-1:0] run_q;

  // saturates at the threshold so a long outage never wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             run_q <= '0;
    else if (|word_i)        run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
  end

  assign run_hit_o = (run_q == RUN_MAX);
endmodule

// File: rtl/lol_hold_timer.sv
module lol_hold_timer
  import lol_alarm_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 15552,
  localparam int unsigned HW = cnt_width(HOLD_CYCLES - 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fault_i,
  output logic          alarm_o,
  output logic [HW-1:0] hold_cnt_o
);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  alm_state_e    state_q;
  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ALM_CLEAR;
      cnt_q   <= '0;
    end else if (fault_i) begin
      state_q <= ALM_RAISED;
      cnt_q   <= '0;
    end else if (state_q == ALM_RAISED) begin
      if (cnt_q == HOLD_LAST) begin
        state_q <= ALM_CLEAR;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign alarm_o    = (state_q == ALM_RAISED);
  assign hold_cnt_o = cnt_q;
endmodule

// File: rtl/lol_alarm.sv
module lol_alarm
  import lol_alarm_pkg::*;
#(
  parameter int unsigned WORD_W         = 16,
  parameter int unsigned ZERO_RUN_WORDS = 514,
  parameter int unsigned HOLD_CYCLES    = 15552,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              lock_ok_i,
  input  logic              lock_mode_i,
  output logic              lol_o
);
  localparam int unsigned HW = cnt_width(HOLD_CYCLES - 1);

  logic          lock_sync;
  logic          zero_hit;
  logic          fault;
  logic [HW-1:0] hold_cnt;

  // reset to "not locked": lock must be proven after reset
  lol_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_lock_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lock_ok_i),
    .q_o   (lock_sync)
  );

  lol_zero_run #(.WORD_W(WORD_W), .RUN_LEN(ZERO_RUN_WORDS)) i_zero_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .word_i   (word_i),
    .run_hit_o(zero_hit)
  );

  assign fault = zero_hit | (lock_mode_i & ~lock_sync);

  lol_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fault_i   (fault),
    .alarm_o   (lol_o),
    .hold_cnt_o(hold_cnt)
  );
endmodule

// File: rtl/lol_alarm_chk.sv
module lol_alarm_chk #(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned HOLD_CYCLES = 15552,
  parameter int unsigned HW          = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] word_i,
  input logic              lock_ok_i,
  input logic              lock_mode_i,
  input logic              lock_s,
  input logic              zero_flt,
  input logic              fault,
  input logic [HW-1:0]     hold_cnt,
  input logic              lol_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_low_R1: assert (lol_o == 1'b0);
  end

  assert_zero_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_flt |=> lol_o);

  assert_run_break_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|word_i) |=> !zero_flt);

  assert_mode_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lol_o) |-> $past(zero_flt || (lock_mode_i && !lock_s)));

  assert_lock_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (lock_s == $past(lock_ok_i, 2)));

  assert_hold_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lol_o && !fault && hold_cnt != HW'(HOLD_CYCLES - 1)) |=> lol_o);

  assert_hold_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lol_o && !fault && hold_cnt == HW'(HOLD_CYCLES - 1)) |=> !lol_o);

  assert_lock_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_mode_i && !lock_s) |=> lol_o);

  assert_fault_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (lol_o && hold_cnt == '0));
endmodule

bind lol_alarm lol_alarm_chk #(
  .WORD_W     (WORD_W),
  .HOLD_CYCLES(HOLD_CYCLES),
  .HW         (HW)
) i_lol_alarm_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .word_i     (word_i),
  .lock_ok_i  (lock_ok_i),
  .lock_mode_i(lock_mode_i),
  .lock_s     (lock_sync),
  .zero_flt   (zero_hit),
  .fault      (fault),
  .hold_cnt   (hold_cnt),
  .lol_o      (lol_o)
);

// File: tb/test_lol_alarm.sv
module test_lol_alarm;
  localparam int ZR   = 12;
  localparam int HOLD = 40;
  localparam int W    = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] word_i = '1;
  logic         lock_ok_i = 1'b1;
  logic         lock_mode_i = 1'b0;
  logic         lol_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit m_s1, m_s2, m_alarm;
  int m_zrun, m_hcnt;

  always #10 clk_i = ~clk_i;

  lol_alarm #(.WORD_W(W), .ZERO_RUN_WORDS(ZR), .HOLD_CYCLES(HOLD)) i_lol_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i),
    .lock_ok_i(lock_ok_i), .lock_mode_i(lock_mode_i), .lol_o(lol_o)
  );

  function automatic bit ref_fault(int zrun, bit mode, bit s2);
    return (zrun == ZR) || (mode && !s2);
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lol_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = 0; m_s2 = 0; m_alarm = 0; m_zrun = 0; m_hcnt = 0;
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic step(logic [W-1:0] d, bit l, string tag);
    bit f;
    word_i = d; lock_ok_i = l;
    @(posedge clk_i);
    f = ref_fault(m_zrun, lock_mode_i, m_s2);
    m_s2 = m_s1; m_s1 = l;
    m_zrun = (d == 0) ? ((m_zrun < ZR) ? m_zrun + 1 : ZR) : 0;
    if (f) begin m_alarm = 1; m_hcnt = 0; end
    else if (m_alarm) begin
      if (m_hcnt == HOLD - 1) begin m_alarm = 0; m_hcnt = 0; end
      else m_hcnt++;
    end
    @(negedge clk_i);
    check(lol_o, m_alarm, tag);
  endtask

  task automatic steps(int n, logic [W-1:0] d, bit l, string tag);
    for (int i = 0; i < n; i++) step(d, l, tag);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk_i);
    check(lol_o, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    step(16'h00ff, 1, "R1 after release");
    steps(4, 16'h1234, 1, "R1 idle");

    // R2: threshold exactly
    steps(ZR, 16'h0000, 1, "R2 run below trigger");
    check(lol_o, 1'b0, "R2 still low after ZR zeros");
    step(16'h0000, 1, "R2 run");
    check(lol_o, 1'b1, "R2 raised after ZR+1 edges");

    // R6: hold-off length
    for (int i = 1; i <= HOLD + 1; i++) begin
      step(16'h0001, 1, "R6 hold");
      if (i == HOLD)     check(lol_o, 1'b1, "R6 held at last hold cycle");
      if (i == HOLD + 1) check(lol_o, 1'b0, "R6 dropped after hold");
    end

    // R3: single set bit breaks the run
    steps(ZR - 1, 16'h0000, 1, "R3 first run");
    step(16'h8000, 1, "R3 break word");
    steps(ZR - 1, 16'h0000, 1, "R3 second run");
    check(lol_o, 1'b0, "R3 no alarm after broken run");
    steps(3, 16'hffff, 1, "R3 tail");

    // R4: lock ignored with mode off
    steps(30, 16'h5a5a, 0, "R4 lock low mode off");
    check(lol_o, 1'b0, "R4 lock ignored");
    steps(5, 16'h5a5a, 1, "R4 relock");

    // R5: lock term with mode on
    lock_mode_i = 1'b1;
    steps(3, 16'h5a5a, 1, "R5 locked");
    check(lol_o, 1'b0, "R5 locked no alarm");
    steps(2, 16'h5a5a, 0, "R5 sync delay");
    check(lol_o, 1'b0, "R5 low during sync");
    step(16'h5a5a, 0, "R5 edge3");
    check(lol_o, 1'b1, "R5 raised third edge");

    // R7: both faults, only one clears
    steps(ZR + 5, 16'h0000, 0, "R7 both faults");
    steps(HOLD + 10, 16'h0000, 1, "R7 zero run persists");
    check(lol_o, 1'b1, "R7 held while zero run remains");
    steps(HOLD + 10, 16'h0f00, 0, "R7 lock loss persists");
    check(lol_o, 1'b1, "R7 held while unlocked");
    steps(HOLD + 3, 16'h0f00, 1, "R7 both clear");
    check(lol_o, 1'b0, "R7 dropped after both clear");

    // R8: glitch during hold restarts count
    step(16'h0f00, 0, "R8 fault pulse");
    steps(4, 16'h0f00, 1, "R8 fault clears");
    steps(HOLD / 2, 16'h0f00, 1, "R8 partial hold");
    step(16'h0f00, 0, "R8 glitch");
    steps(HOLD - 5, 16'h0f00, 1, "R8 after glitch");
    check(lol_o, 1'b1, "R8 hold restarted");
    steps(HOLD, 16'h0f00, 1, "R8 finish");
    check(lol_o, 1'b0, "R8 finally clear");

    // random mix, compared every cycle
    begin
      int zb = 0;
      bit lk = 1;
      for (int c = 0; c < 6000; c++) begin
        logic [W-1:0] d;
        if (c % 700 == 0) lock_mode_i = $urandom_range(0, 1);
        if ($urandom_range(0, 60) == 0) lk = ~lk;
        if (zb == 0 && $urandom_range(0, 25) == 0) zb = $urandom_range(1, 2 * ZR);
        if (zb > 0) begin d = '0; zb--; end
        else if ($urandom_range(0, 3) == 0) d = W'(1) << $urandom_range(0, W - 1);
        else d = W'($urandom);
        step(d, lk, "R6 random mix");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule